// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a 16-bit up-counter fed by a single asynchronous input pin. In event mode it adds one for every edge of a chosen polarity seen on the pin. In gated mode it adds one for every tick of a free-running divide-by-64 prescaler on the bus clock, but only while the pin sits at its active level. This lets one counter measure either a count of events or the length of time a signal is held.

Software controls it with level-style register bits: an accumulator enable, a mode bit, a polarity bit and an overflow interrupt enable. It can load any 16-bit value into the counter with a one-cycle write strobe. It clears the overflow flag with a write-one-to-clear strobe. The flag is set only when the count wraps from 0xFFFF to 0x0000, and the interrupt line is that flag masked by its enable. Event counting depends only on the accumulator's own enable. The block has no link to any other timer's enable.

Top module: `pulse_accum`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count` is 0x0000, `ovf_flag` is 0 and `irq` is 0.
- R2: With `mode_gated`=0, `count` gains exactly one for each edge of the synchronized pin whose direction matches `pol_sel` (1 = low-to-high, 0 = high-to-low). Edges of the other direction leave it unchanged. Every pulse held for at least three bus cycles is counted.
- R3: With `mode_gated`=1, `count` gains one each 64 bus cycles while the synchronized pin equals `pol_sel`. It does not move while the pin is at the other level. The prescaler restarts from zero while `acc_en` is low, so the first increment lands on the 64th rising clock edge after `acc_en` goes high.
- R4: `ovf_flag` is set only by a counter step from 0xFFFF to 0x0000. A step that reaches 0xFFFF, or any other value, does not set it.
- R5: `irq` is high exactly when `ovf_flag` is 1 and `ovf_ie` is 1.
- R6: While `acc_en` is low, `count` holds in both modes, whatever the pin does.
- R7: A cycle with `cnt_wr` high loads `cnt_wdata` into `count` on that clock edge. This overrides an increment due in the same cycle.
- R8: A cycle with `ovf_clr` high clears `ovf_flag`. If a rollover happens in the same cycle, the flag is set instead.
- R9: The pin passes through two synchronizer flops and one edge-history flop. An edge applied just after clock edge k is reflected in `count` at edge k+3 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous accumulator input |
| acc_en | input | 1 | Accumulator enable |
| mode_gated | input | 1 | 0 = edge counting, 1 = gated time accumulation |
| pol_sel | input | 1 | Edge select (event) or active gate level (gated) |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Value loaded by `cnt_wr` |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | 16 | Current accumulator value |
| ovf_flag | output | 1 | Rollover flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench places a software load and an edge-driven increment in the same cycle. A design with the wrong priority would return the loaded value plus one. It also places a flag clear on the cycle of a rollover, where a design with the wrong priority would lose the overflow. The bench steps the count from 0xFFFE to 0xFFFF and then to 0x0000. This catches a flag that is set on reaching the all-ones value instead of on the wrap. Gated counting is sampled a few cycles after whole multiples of 64 from enable. A prescaler that free-runs through the disabled period, or that divides by the wrong ratio, shows up as a count off by one or more. Counting the edge three clock edges after the pin moves exposes a synchronizer that is missing a stage or has an extra one.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int CNT_W   = 16;
  localparam int PRE_DIV = 64;
  localparam int SYNC_N  = 2;

  typedef enum logic {
    MODE_EVENT = 1'b0,
    MODE_GATED = 1'b1
  } pacc_mode_e;
endpackage

// File: rtl/pacc_insync.sv
module pacc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      hist_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      hist_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~hist_q;
  assign fall_o  = ~chain_q[STAGES-1] & hist_q;
endmodule

// File: rtl/pacc_presc.sv
module pacc_presc #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)   div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == LAST);

  // R3: ticks are spaced by the full divide ratio, never back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         inc_req_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  logic [W-1:0] cnt_q;
  logic         flag_q;
  logic         step;
  logic         wrap;

  assign step = en_i && inc_req_i && !wr_i;
  assign wrap = step && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (wrap)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  a_r4_flag_on_wrap_only: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (cnt_q == '0 && $past(cnt_q) == {W{1'b1}}));

  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !wr_i) |=> cnt_q == $past(cnt_q));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> cnt_q == $past(wdata_i));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             acc_en,
  input  logic             mode_gated,
  input  logic             pol_sel,
  input  logic             ovf_ie,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq
);
  pacc_mode_e mode;
  logic       pin_lvl, pin_rise, pin_fall;
  logic       tick;
  logic       inc_req;

  assign mode = pacc_mode_e'(mode_gated);

  pacc_insync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in),
    .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  pacc_presc #(.DIV(PRE_DIV)) u_presc (
    .clk(clk), .rst(rst), .run_i(acc_en), .tick_o(tick)
  );

  always_comb begin
    unique case (mode)
      MODE_GATED: inc_req = tick && (pin_lvl == pol_sel);
      default:    inc_req = pol_sel ? pin_rise : pin_fall;
    endcase
  end

  pacc_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en_i(acc_en), .inc_req_i(inc_req),
    .wr_i(cnt_wr), .wdata_i(cnt_wdata), .clr_i(ovf_clr),
    .cnt_o(count), .flag_o(ovf_flag)
  );

  assign irq = ovf_flag & ovf_ie;

  // R5: a request never appears without a pending overflow
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 1'b0;
  logic        acc_en = 1'b0;
  logic        mode_gated = 1'b0;
  logic        pol_sel = 1'b1;
  logic        ovf_ie = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = 16'h0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pulse_accum dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .acc_en(acc_en),
    .mode_gated(mode_gated), .pol_sel(pol_sel), .ovf_ie(ovf_ie),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct packed {
    logic       en;
    logic       pol;
    logic       idle;
    logic [7:0] pulses;
    logic [7:0] width;
    logic [7:0] expect_n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{en:1'b1, pol:1'b1, idle:1'b0, pulses:8'd5, width:8'd3, expect_n:8'd5},
    '{en:1'b1, pol:1'b0, idle:1'b0, pulses:8'd4, width:8'd3, expect_n:8'd4},
    '{en:1'b1, pol:1'b0, idle:1'b1, pulses:8'd7, width:8'd4, expect_n:8'd7},
    '{en:1'b1, pol:1'b1, idle:1'b1, pulses:8'd3, width:8'd5, expect_n:8'd3},
    '{en:1'b0, pol:1'b1, idle:1'b0, pulses:8'd6, width:8'd3, expect_n:8'd0},
    '{en:1'b1, pol:1'b1, idle:1'b0, pulses:8'd1, width:8'd3, expect_n:8'd1}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic pulse_train(input logic idle, input int n, input int w);
    for (int i = 0; i < n; i++) begin
      pin_in = ~idle; cyc(w);
      pin_in = idle;  cyc(w);
    end
  endtask

  initial begin
    cyc(3);
    chk("R1 count in reset", count, 16'h0);
    chk("R1 flag in reset", ovf_flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count after reset", count, 16'h0);
    chk("R1 irq after reset", irq, 1'b0);

    // R2 / R6: vector walk in event mode
    mode_gated = 1'b0;
    for (int k = 0; k < 6; k++) begin
      acc_en  = 1'b1;
      pol_sel = VEC[k].pol;
      pin_in  = VEC[k].idle;
      cyc(6);
      load(16'h0);
      acc_en = VEC[k].en;
      pulse_train(VEC[k].idle, int'(VEC[k].pulses), int'(VEC[k].width));
      cyc(6);
      chk(VEC[k].en ? "R2 event count" : "R6 event disabled", count, {8'h0, VEC[k].expect_n});
    end

    // R3: gated accumulation
    acc_en = 1'b0; mode_gated = 1'b1; pol_sel = 1'b1; pin_in = 1'b1;
    cyc(6);
    load(16'h0);
    acc_en = 1'b1;
    cyc(64 * 3 + 10);
    chk("R3 gated high level", count, 16'd3);
    pin_in = 1'b0;
    cyc(200);
    chk("R3 gate inactive", count, 16'd3);
    pol_sel = 1'b0;
    cyc(128);
    chk("R3 gated low level", count, 16'd5);
    acc_en = 1'b0;
    cyc(200);
    chk("R6 gated disabled", count, 16'd5);

    // R4 / R5 / R8: overflow behaviour
    mode_gated = 1'b0; pol_sel = 1'b1; pin_in = 1'b0; acc_en = 1'b1; ovf_ie = 1'b1;
    cyc(6);
    load(16'hFFFE);
    pulse_train(1'b0, 1, 3); cyc(4);
    chk("R4 count reaches all ones", count, 16'hFFFF);
    chk("R4 no flag at all ones", ovf_flag, 1'b0);
    pulse_train(1'b0, 1, 3); cyc(4);
    chk("R4 wrap count", count, 16'h0);
    chk("R4 flag on wrap", ovf_flag, 1'b1);
    chk("R5 irq enabled", irq, 1'b1);
    ovf_ie = 1'b0; #1;
    chk("R5 irq masked", irq, 1'b0);
    ovf_ie = 1'b1;
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8 clear", ovf_flag, 1'b0);

    // R9: latency through synchronizer
    load(16'h0010);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet counted", count, 16'h0010);
    @(negedge clk);
    chk("R9 counted at third edge", count, 16'h0011);

    // R7: load collides with increment
    pin_in = 1'b0; cyc(6);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 16'h1234;
    @(negedge clk); cnt_wr = 1'b0;
    cyc(4);
    chk("R7 load beats increment", count, 16'h1234);

    // R8: clear collides with rollover
    pin_in = 1'b0; cyc(6);
    load(16'hFFFF);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8 rollover beats clear", ovf_flag, 1'b1);
    chk("R8 wrapped value", count, 16'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule